// File: doc/BRIEF.md
# Byte-Serial Operand Address Fetcher

This block fetches instructions one byte at a time for an 8-bit accumulator machine with a 16-bit byte address space. It reads the opcode byte and, from that byte alone, decides how many operand bytes follow. It then reads those bytes and forms the effective address of the instruction. The supported forms are:

- a full 16-bit address;
- an address within the first 256-byte page;
- a full address offset by an index register;
- a branch target reached through a signed one-byte displacement.

Each formed address is presented for one cycle, together with the program counter of the following instruction. An opcode outside the supported set raises a one-cycle flag, and fetching resumes at the next byte. The fetcher drives a byte-wide read port. A read is accepted in a cycle where both the request and ready are high, and its data arrives on the next cycle.

Top module: `opf_fetch_top`

## Requirements
- R1: While rst_ni is low, the outputs are ea_valid_o=0 and illegal_o=0, next_pc_o equals start_pc_i, and a read request is driven at start_pc_i. The first opcode fetch after reset uses that address.
- R2: A read is accepted in a cycle where mem_req_o and mem_ready_i are both high, and its data is sampled on the next cycle. While mem_ready_i is low, the request and its address hold steady, and every byte is still fetched exactly once, in order.
- R3: Opcode 0xAD takes two operand bytes: the first read is the low address byte and the second is the high address byte. It yields ea_o={high,low}, ea_kind_o=0, and next_pc_o = opcode address + 3.
- R4: Opcode 0xA5 takes one operand byte. It yields ea_o={0x00,byte} and ea_kind_o=1. The next read is the following opcode at opcode address + 2; no third byte is fetched.
- R5: Opcode 0xBD takes two operand bytes, low byte first. It yields ea_o=({high,low}+x_i) mod 65536, ea_kind_o=2, and next_pc_o = opcode address + 3. x_i is held stable until ea_valid_o.
- R6: Opcode 0xD0 takes a one-byte displacement d. It yields ea_o=(opcode address + 2 + sign-extended d) mod 65536, ea_kind_o=3, and next_pc_o = (opcode address + 2) mod 65536.
- R7: Any other opcode pulses illegal_o for one cycle, two cycles after the opcode read is accepted, and raises no ea_valid_o. At that pulse, next_pc_o = opcode address + 1, and the next read is at that address.
- R8: The opcode of the next instruction is read from the address right after the last byte of the current one. The program counter wraps mod 65536.
- R9: ea_valid_o is a single-cycle pulse. It comes exactly two cycles after the cycle in which the last operand read is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_pc_i | input | 16 | Program counter value loaded on reset |
| x_i | input | 8 | Index register value for the indexed form |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | 16 | Read address |
| mem_ready_i | input | 1 | Memory accepts the request this cycle |
| mem_rdata_i | input | 8 | Read data, valid one cycle after acceptance |
| ea_valid_o | output | 1 | Effective address valid pulse |
| ea_o | output | 16 | Effective address |
| ea_kind_o | output | 2 | Address form: 0 full, 1 page-zero, 2 indexed, 3 branch |
| next_pc_o | output | 16 | Program counter of the next byte to fetch |
| illegal_o | output | 1 | Unsupported opcode pulse |

## Verification
Each accepted read costs two cycles: the request cycle and the data cycle. A result pulse, either ea_valid_o or illegal_o, appears two cycles after the acceptance of the last byte it depends on. The bench samples on falling edges and logs the cycle of every accepted read and every pulse. The checks compare pulse cycles to read cycles plus two, and compare the logged addresses to the expected byte order. This holds whether ready stalls or not.

// File: rtl/opf_pkg.sv
package opf_pkg;
  localparam logic [7:0] OP_LD_FULL = 8'hAD;
  localparam logic [7:0] OP_LD_PAGE0 = 8'hA5;
  localparam logic [7:0] OP_LD_INDEX = 8'hBD;
  localparam logic [7:0] OP_BR_REL = 8'hD0;

  typedef enum logic [1:0] {
    EA_FULL  = 2'd0,
    EA_PAGE0 = 2'd1,
    EA_INDEX = 2'd2,
    EA_REL   = 2'd3
  } ea_kind_e;

  typedef enum logic [2:0] {
    ST_OP_REQ, ST_OP_DAT, ST_LO_REQ, ST_LO_DAT, ST_HI_REQ, ST_HI_DAT
  } fsm_e;
endpackage

// File: rtl/opf_decode.sv
module opf_decode
  import opf_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] opcode_i,
  output logic              legal_o,
  output logic              two_byte_o,
  output ea_kind_e          kind_o
);
  always_comb begin
    legal_o    = 1'b1;
    two_byte_o = 1'b0;
    kind_o     = EA_FULL;
    case (opcode_i)
      OP_LD_FULL:  two_byte_o = 1'b1;
      OP_LD_INDEX: begin two_byte_o = 1'b1; kind_o = EA_INDEX; end
      OP_LD_PAGE0: kind_o = EA_PAGE0;
      OP_BR_REL:   kind_o = EA_REL;
      default:     legal_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/opf_ea_calc.sv
module opf_ea_calc
  import opf_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int ADDR_W = 2 * BYTE_W
) (
  input  ea_kind_e          kind_i,
  input  logic [BYTE_W-1:0] lo_i,
  input  logic [BYTE_W-1:0] hi_i,
  input  logic [BYTE_W-1:0] x_i,
  input  logic [ADDR_W-1:0] pc_after_i,
  output logic [ADDR_W-1:0] ea_o
);
  logic [ADDR_W-1:0] base;
  assign base = {hi_i, lo_i};

  always_comb begin
    case (kind_i)
      EA_FULL:  ea_o = base;
      EA_PAGE0: ea_o = {{BYTE_W{1'b0}}, lo_i};
      EA_INDEX: ea_o = base + {{BYTE_W{1'b0}}, x_i};
      default:  ea_o = pc_after_i + {{BYTE_W{lo_i[BYTE_W-1]}}, lo_i};
    endcase
  end
endmodule

// File: rtl/opf_fetch_top.sv
module opf_fetch_top
  import opf_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int ADDR_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] start_pc_i,
  input  logic [BYTE_W-1:0] x_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ready_i,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  output logic              ea_valid_o,
  output logic [ADDR_W-1:0] ea_o,
  output logic [1:0]        ea_kind_o,
  output logic [ADDR_W-1:0] next_pc_o,
  output logic              illegal_o
);
  fsm_e              state_q;
  logic [ADDR_W-1:0] pc_q, ea_q, ea_d, pc_inc;
  logic [BYTE_W-1:0] lo_q, lo_sel;
  ea_kind_e          kind_q, dec_kind;
  logic              two_q, dec_legal, dec_two, valid_q, illegal_q;

  opf_decode #(.BYTE_W(BYTE_W)) i_dec (
    .opcode_i(mem_rdata_i), .legal_o(dec_legal),
    .two_byte_o(dec_two), .kind_o(dec_kind)
  );

  // last operand byte is either the live low byte or the live high byte
  assign lo_sel = (state_q == ST_LO_DAT) ? mem_rdata_i : lo_q;
  assign pc_inc = pc_q + 1'b1;

  opf_ea_calc #(.BYTE_W(BYTE_W)) i_ea (
    .kind_i(kind_q), .lo_i(lo_sel), .hi_i(mem_rdata_i),
    .x_i(x_i), .pc_after_i(pc_inc), .ea_o(ea_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_OP_REQ;
      pc_q      <= start_pc_i;
      ea_q      <= '0;
      lo_q      <= '0;
      kind_q    <= EA_FULL;
      two_q     <= 1'b0;
      valid_q   <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      valid_q   <= 1'b0;
      illegal_q <= 1'b0;
      case (state_q)
        ST_OP_REQ: if (mem_ready_i) state_q <= ST_OP_DAT;
        ST_LO_REQ: if (mem_ready_i) state_q <= ST_LO_DAT;
        ST_HI_REQ: if (mem_ready_i) state_q <= ST_HI_DAT;
        ST_OP_DAT: begin
          pc_q <= pc_inc;
          if (dec_legal) begin
            kind_q  <= dec_kind;
            two_q   <= dec_two;
            state_q <= ST_LO_REQ;
          end else begin
            illegal_q <= 1'b1;
            state_q   <= ST_OP_REQ;
          end
        end
        ST_LO_DAT: begin
          pc_q <= pc_inc;
          lo_q <= mem_rdata_i;
          if (two_q) begin
            state_q <= ST_HI_REQ;
          end else begin
            ea_q    <= ea_d;
            valid_q <= 1'b1;
            state_q <= ST_OP_REQ;
          end
        end
        ST_HI_DAT: begin
          pc_q    <= pc_inc;
          ea_q    <= ea_d;
          valid_q <= 1'b1;
          state_q <= ST_OP_REQ;
        end
        default: state_q <= ST_OP_REQ;
      endcase
    end
  end

  assign mem_req_o  = (state_q == ST_OP_REQ) || (state_q == ST_LO_REQ) ||
                      (state_q == ST_HI_REQ);
  assign mem_addr_o = pc_q;
  assign ea_valid_o = valid_q;
  assign ea_o       = ea_q;
  assign ea_kind_o  = kind_q;
  assign next_pc_o  = pc_q;
  assign illegal_o  = illegal_q;

  a_r2_hold_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o));
  a_r9_ea_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ea_valid_o |=> !ea_valid_o);
  a_r7_illegal_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> !illegal_o);
  a_r7_no_ea_on_illegal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(illegal_o && ea_valid_o));
  a_r4_page0_high_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ea_valid_o && ea_kind_o == EA_PAGE0 |-> ea_o[ADDR_W-1:BYTE_W] == '0);
  a_r8_next_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ea_valid_o |-> next_pc_o == $past(mem_addr_o, 2) + 1'b1);
  a_r7_skip_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> next_pc_o == $past(mem_addr_o, 2) + 1'b1);
endmodule

// File: tb/test_opf_fetch_top.sv
module test_opf_fetch_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] start_pc = 16'h0;
  logic [7:0]  x_val = 8'h0;
  logic        req;
  logic [15:0] addr;
  logic        ready = 1'b1;
  logic [7:0]  rdata = 8'h0;
  logic        ea_valid, illegal;
  logic [15:0] ea, next_pc;
  logic [1:0]  kind;
  logic        stall_en = 1'b0;

  logic [7:0] mem [logic [15:0]];

  int tests = 0, fails = 0, cyc = 0;
  logic [15:0] acc_addr [64]; int acc_cyc [64]; int acc_n = 0;
  logic [15:0] ev_ea [16]; logic [15:0] ev_pc [16]; logic [1:0] ev_kind [16];
  int ev_cyc [16]; int ev_n = 0;
  logic [15:0] ill_pc [16]; int ill_cyc [16]; int ill_n = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  opf_fetch_top i_opf_fetch_top (
    .clk_i(clk), .rst_ni(rst_n), .start_pc_i(start_pc), .x_i(x_val),
    .mem_req_o(req), .mem_addr_o(addr), .mem_ready_i(ready),
    .mem_rdata_i(rdata), .ea_valid_o(ea_valid), .ea_o(ea),
    .ea_kind_o(kind), .next_pc_o(next_pc), .illegal_o(illegal)
  );

  function automatic logic [7:0] rd(logic [15:0] a);
    return mem.exists(a) ? mem[a] : 8'hEA;
  endfunction

  // memory model: one cycle of read latency, optional alternating ready
  always @(posedge clk) begin
    if (req && ready) rdata <= rd(addr);
    ready <= stall_en ? ~ready : 1'b1;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (req && ready && acc_n < 64) begin
        acc_addr[acc_n] = addr; acc_cyc[acc_n] = cyc; acc_n++;
      end
      if (ea_valid && ev_n < 16) begin
        ev_ea[ev_n] = ea; ev_pc[ev_n] = next_pc; ev_kind[ev_n] = kind;
        ev_cyc[ev_n] = cyc; ev_n++;
      end
      if (illegal && ill_n < 16) begin
        ill_pc[ill_n] = next_pc; ill_cyc[ill_n] = cyc; ill_n++;
      end
    end
  end

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic chk_eq(input string rq, input int act, input int exp);
    check(act == exp, rq, act, exp);
  endtask

  task automatic begin_test(input logic [15:0] pc, input logic [7:0] x, input bit st);
    @(negedge clk);
    rst_n = 1'b0;
    start_pc = pc; x_val = x; stall_en = st;
    mem.delete();
    acc_n = 0; ev_n = 0; ill_n = 0; cyc = 0;
  endtask

  task automatic poke(input logic [15:0] a, input logic [7:0] d);
    mem[a] = d;
  endtask

  task automatic run_until(input int n_ev);
    int t = 0;
    @(negedge clk);
    rst_n = 1'b1;
    while (ev_n < n_ev && t < 300) begin
      @(negedge clk);
      t++;
    end
    check(ev_n >= n_ev, "R9 ea_valid count", ev_n, n_ev);
  endtask

  task automatic t_reset;
    begin_test(16'h1000, 8'h0, 1'b0);
    poke(16'h1000, 8'hA5); poke(16'h1001, 8'h44);
    @(negedge clk);
    chk_eq("R1 next_pc in reset", next_pc, 16'h1000);
    chk_eq("R1 req in reset", {req, addr}, {1'b1, 16'h1000});
    chk_eq("R1 pulses low", {ea_valid, illegal}, 0);
    run_until(1);
    chk_eq("R1 first fetch at start", acc_addr[0], 16'h1000);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk_eq("R1 async reset pc", next_pc, 16'h1000);
  endtask

  task automatic t_full_page0;
    begin_test(16'h0200, 8'h0, 1'b0);
    poke(16'h0200, 8'hAD); poke(16'h0201, 8'h34); poke(16'h0202, 8'h12);
    poke(16'h0203, 8'hA5); poke(16'h0204, 8'h80);
    run_until(2);
    chk_eq("R3 ea", ev_ea[0], 16'h1234);
    chk_eq("R3 kind", ev_kind[0], 0);
    chk_eq("R3 next_pc", ev_pc[0], 16'h0203);
    chk_eq("R3 byte order", {acc_addr[1], acc_addr[2]}, {16'h0201, 16'h0202});
    chk_eq("R9 ea timing", ev_cyc[0], acc_cyc[2] + 2);
    chk_eq("R4 ea", ev_ea[1], 16'h0080);
    chk_eq("R4 kind", ev_kind[1], 1);
    chk_eq("R4 next_pc", ev_pc[1], 16'h0205);
    chk_eq("R8 next opcode addr", acc_addr[3], 16'h0203);
    chk_eq("R4 no third fetch", acc_addr[5], 16'h0205);
    chk_eq("R9 page0 timing", ev_cyc[1], acc_cyc[4] + 2);
  endtask

  task automatic t_indexed_stall;
    begin_test(16'h0800, 8'h20, 1'b1);
    poke(16'h0800, 8'hBD); poke(16'h0801, 8'hF0); poke(16'h0802, 8'h12);
    poke(16'h0803, 8'hBD); poke(16'h0804, 8'hFF); poke(16'h0805, 8'hFF);
    run_until(2);
    chk_eq("R5 ea", ev_ea[0], 16'h1310);
    chk_eq("R5 kind", ev_kind[0], 2);
    chk_eq("R5 next_pc", ev_pc[0], 16'h0803);
    chk_eq("R5 wrap ea", ev_ea[1], 16'h001F);
    for (int i = 0; i < 6; i++)
      chk_eq("R2 each byte once in order", acc_addr[i], 16'h0800 + i);
    chk_eq("R2 R9 timing under stall", ev_cyc[1], acc_cyc[5] + 2);
  endtask

  task automatic t_branch;
    begin_test(16'h0300, 8'h0, 1'b0);
    poke(16'h0300, 8'hD0); poke(16'h0301, 8'hFE);
    poke(16'h0302, 8'hD0); poke(16'h0303, 8'h7F);
    run_until(2);
    chk_eq("R6 backward ea", ev_ea[0], 16'h0300);
    chk_eq("R6 kind", ev_kind[0], 3);
    chk_eq("R6 next_pc", ev_pc[0], 16'h0302);
    chk_eq("R6 forward ea", ev_ea[1], 16'h0383);
    begin_test(16'hFFFE, 8'h0, 1'b0);
    poke(16'hFFFE, 8'hD0); poke(16'hFFFF, 8'h05);
    poke(16'h0000, 8'hD0); poke(16'h0001, 8'h80);
    run_until(2);
    chk_eq("R8 pc wrap", ev_pc[0], 16'h0000);
    chk_eq("R6 target after wrap", ev_ea[0], 16'h0005);
    chk_eq("R6 negative wrap", ev_ea[1], 16'hFF82);
  endtask

  task automatic t_illegal;
    begin_test(16'h0400, 8'h0, 1'b0);
    poke(16'h0400, 8'h02); poke(16'h0401, 8'hA5); poke(16'h0402, 8'h10);
    run_until(1);
    check(ill_n >= 1, "R7 illegal seen", ill_n, 1);
    chk_eq("R7 illegal pc", ill_pc[0], 16'h0401);
    chk_eq("R7 illegal timing", ill_cyc[0], acc_cyc[0] + 2);
    chk_eq("R7 refetch addr", acc_addr[1], 16'h0401);
    chk_eq("R7 following ea", ev_ea[0], 16'h0010);
    check(ev_cyc[0] != ill_cyc[0], "R7 no ea on illegal", ev_cyc[0], -1);
    check(ill_n < 2 || ill_cyc[1] != ill_cyc[0] + 1, "R7 single pulse",
          ill_cyc[1], ill_cyc[0] + 2);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_full_page0();
    t_indexed_stall();
    t_branch();
    t_illegal();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule